// File: doc/BRIEF.md
# LPC I/O Cycle Target

This block is the peripheral side of a Low Pin Count bus. It watches the 4-bit multiplexed bus and the active-low frame strobe. It recognises a host I/O read or I/O write cycle and collects the 16-bit address. When that address equals the programmable host address, it carries the cycle to its end. On a write, the byte from the host goes into an input data register and sets that register's full flag. On a read, the block returns the byte held in an output register and drives the ready sync and the recovery nibbles. It also controls the output enable of the bus buffer.

Local logic reaches the block through two strobes. One reads and releases the input register. The other loads the output register. All bus-side register and flag updates wait for the target's closing recovery nibble. A cycle that the host abandons earlier therefore changes nothing.

Top module: `lpc_io_target`

## Requirements
- R1: After reset, `lad_oe_o`, `busy_o`, `in_full_o` and `out_full_o` are all 0.
- R2: A read cycle is the clock sequence: start nibble 0000 with `lframe_ni` low, type nibble 0000, four address nibbles (bits 15:12 first), then two host turnaround clocks. On the next clock the target drives sync 0000. On the two clocks after that it drives the output byte, bits 3:0 first and then bits 7:4. On the clock after that it drives 1111. `lad_oe_o` is 1 on exactly those four clocks. The byte sent is the output register's value at the clock that completes the address.
- R3: A write cycle has type nibble 0010. After the address, the host sends two data nibbles, bits 3:0 first. Two host turnaround clocks follow. The target then drives sync 0000 for one clock and 1111 for one clock, with `lad_oe_o` high on exactly those two clocks.
- R4: A cycle proceeds only when the 16-bit address equals `host_addr_i`. Otherwise the block never asserts `lad_oe_o` or `busy_o`, and leaves all registers and flags unchanged.
- R5: A type nibble other than 0000 or 0010 is ignored: no drive, no busy, no register change.
- R6: Updates happen on the clock edge that starts the target's 1111 recovery nibble. A write loads `in_data_o` and sets `in_full_o`. A read clears `out_full_o`.
- R7: `lframe_ni` low at any clock edge ends the cycle in progress. From the next clock, `lad_oe_o` is 0. If this happens before the recovery nibble, no register or flag changes.
- R8: `busy_o` is 1 from the clock after the last address nibble of a matching cycle, up to and including the target's sync and data clocks. It is 0 from the recovery nibble on.
- R9: `in_rd_i` clears `in_full_o`. `out_wr_i` loads the output register from `out_wdata_i` and sets `out_full_o`. A host write commit in the same clock as `in_rd_i` leaves `in_full_o` set. `out_wr_i` in the same clock as a read commit leaves `out_full_o` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lframe_ni | input | 1 | Cycle frame strobe, active low |
| lad_i | input | 4 | Bus nibble as received |
| lad_o | output | 4 | Bus nibble to drive |
| lad_oe_o | output | 1 | Bus output enable |
| host_addr_i | input | 16 | I/O address claimed by this target |
| out_wr_i | input | 1 | Local strobe: load output register |
| out_wdata_i | input | 8 | Byte for the output register |
| out_full_o | output | 1 | Output register holds a byte not yet read by the host |
| in_rd_i | input | 1 | Local strobe: release input register |
| in_data_o | output | 8 | Last byte written by the host |
| in_full_o | output | 1 | Input register holds an unreleased byte |
| busy_o | output | 1 | Matching cycle in progress |

## Verification
The hardest situations to reach are a host abort that lands exactly on a clock where the target is already driving (sync, a data nibble) or one clock after the commit, and local strobes that coincide with the commit edge. The bench's cycle task takes a step number at which to pull the frame strobe low and step numbers at which to pulse each local strobe. This places these events on clock 9, 11 or 12 of a 13-clock cycle. A behavioural model then recomputes the expected nibble, enable, busy and flags for every clock.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_IORD  = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_IOWR  = 4'b0010;
  localparam logic [NIB_W-1:0] NIB_READY = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_TAR   = 4'b1111;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TYPE, ST_ADDR, ST_WDAT, ST_HTAR0,
    ST_HTAR1, ST_SYNC, ST_RDAT, ST_TTAR0, ST_TTAR1
  } lpc_st_e;
endpackage

// File: rtl/lpc_frame_fsm.sv
module lpc_frame_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lframe_ni,
  input  logic [NIB_W-1:0]  lad_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output lpc_st_e           st_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] wbuf_o,
  output logic              match_o,
  output logic              commit_wr_o,
  output logic              commit_rd_o
);
  localparam int ADDR_NIB = ADDR_W / NIB_W;
  localparam int DATA_NIB = DATA_W / NIB_W;

  lpc_st_e           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wbuf_q, wbuf_n;
  logic              wr_q, wr_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    wbuf_n = wbuf_q;
    wr_n   = wr_q;
    if (!lframe_ni) begin
      // frame low: abort anything, restart on a start nibble
      st_n  = (lad_i == NIB_START) ? ST_TYPE : ST_IDLE;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: st_n = ST_IDLE;
        ST_TYPE: begin
          cnt_n = '0;
          if (lad_i == NIB_IORD) begin
            wr_n = 1'b0; st_n = ST_ADDR;
          end else if (lad_i == NIB_IOWR) begin
            wr_n = 1'b1; st_n = ST_ADDR;
          end else begin
            st_n = ST_IDLE;
          end
        end
        ST_ADDR: begin
          addr_n = {addr_q[ADDR_W-NIB_W-1:0], lad_i};
          if (cnt_q == CNT_W'(ADDR_NIB-1)) begin
            cnt_n = '0;
            if (addr_n == host_addr_i) st_n = wr_q ? ST_WDAT : ST_HTAR0;
            else                       st_n = ST_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_WDAT: begin
          wbuf_n = {lad_i, wbuf_q[DATA_W-1:NIB_W]};
          if (cnt_q == CNT_W'(DATA_NIB-1)) begin
            cnt_n = '0; st_n = ST_HTAR0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_HTAR0: st_n = ST_HTAR1;
        ST_HTAR1: st_n = ST_SYNC;
        ST_SYNC: begin
          cnt_n = '0;
          st_n  = wr_q ? ST_TTAR0 : ST_RDAT;
        end
        ST_RDAT: begin
          if (cnt_q == CNT_W'(DATA_NIB-1)) begin
            cnt_n = '0; st_n = ST_TTAR0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_TTAR0: st_n = ST_TTAR1;
        ST_TTAR1: st_n = ST_IDLE;
        default:  st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      wbuf_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      wbuf_q <= wbuf_n;
      wr_q   <= wr_n;
    end
  end

  logic enter_rec;
  assign enter_rec   = (st_n == ST_TTAR0) && (st_q != ST_TTAR0);
  assign commit_wr_o = enter_rec && wr_q;
  assign commit_rd_o = enter_rec && !wr_q;
  assign match_o     = (st_q == ST_ADDR) && (st_n != ST_IDLE) && (st_n != ST_TYPE)
                       && (st_n != ST_ADDR);
  assign st_o        = st_q;
  assign cnt_o       = cnt_q;
  assign wbuf_o      = wbuf_q;
endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
  import lpc_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 1
) (
  input  lpc_st_e           st_i,
  input  logic [SEL_W-1:0]  nib_sel_i,
  input  logic [DATA_W-1:0] rd_byte_i,
  output logic [NIB_W-1:0]  lad_o,
  output logic              lad_oe_o
);
  localparam int DATA_NIB = DATA_W / NIB_W;

  logic [NIB_W-1:0] nibs [DATA_NIB];
  for (genvar g = 0; g < DATA_NIB; g++) begin : g_nib
    assign nibs[g] = rd_byte_i[g*NIB_W +: NIB_W];
  end

  always_comb begin
    lad_o    = NIB_TAR;
    lad_oe_o = 1'b0;
    unique case (st_i)
      ST_SYNC:  begin lad_o = NIB_READY;       lad_oe_o = 1'b1; end
      ST_RDAT:  begin lad_o = nibs[nib_sel_i]; lad_oe_o = 1'b1; end
      ST_TTAR0: begin lad_o = NIB_TAR;         lad_oe_o = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/lpc_tgt_regs.sv
module lpc_tgt_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_wr_i,
  input  logic              commit_rd_i,
  input  logic              snap_i,
  input  logic [DATA_W-1:0] wbuf_i,
  input  logic              in_rd_i,
  input  logic              out_wr_i,
  input  logic [DATA_W-1:0] out_wdata_i,
  output logic [DATA_W-1:0] in_data_o,
  output logic              in_full_o,
  output logic              out_full_o,
  output logic [DATA_W-1:0] rd_byte_o
);
  logic [DATA_W-1:0] out_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data_o  <= '0;
      in_full_o  <= 1'b0;
      out_data_q <= '0;
      out_full_o <= 1'b0;
      rd_byte_o  <= '0;
    end else begin
      // host commit beats local release
      if (commit_wr_i) begin
        in_data_o <= wbuf_i;
        in_full_o <= 1'b1;
      end else if (in_rd_i) begin
        in_full_o <= 1'b0;
      end
      // local load beats host read-out
      if (out_wr_i) begin
        out_data_q <= out_wdata_i;
        out_full_o <= 1'b1;
      end else if (commit_rd_i) begin
        out_full_o <= 1'b0;
      end
      if (snap_i) rd_byte_o <= out_data_q;
    end
  end
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              out_wr_i,
  input  logic [DATA_W-1:0] out_wdata_i,
  output logic              out_full_o,
  input  logic              in_rd_i,
  output logic [DATA_W-1:0] in_data_o,
  output logic              in_full_o,
  output logic              busy_o
);
  localparam int ADDR_NIB = ADDR_W / NIB_W;
  localparam int DATA_NIB = DATA_W / NIB_W;
  localparam int MAX_NIB  = (ADDR_NIB > DATA_NIB) ? ADDR_NIB : DATA_NIB;
  localparam int CNT_W    = (MAX_NIB > 1) ? $clog2(MAX_NIB) : 1;
  localparam int SEL_W    = (DATA_NIB > 1) ? $clog2(DATA_NIB) : 1;

  lpc_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] wbuf, rd_byte;
  logic              match, commit_wr, commit_rd;

  lpc_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .lframe_ni, .lad_i, .host_addr_i,
    .st_o(st), .cnt_o(cnt), .wbuf_o(wbuf), .match_o(match),
    .commit_wr_o(commit_wr), .commit_rd_o(commit_rd)
  );

  lpc_lad_drive #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_drv (
    .st_i(st), .nib_sel_i(cnt[SEL_W-1:0]), .rd_byte_i(rd_byte),
    .lad_o, .lad_oe_o
  );

  lpc_tgt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .commit_wr_i(commit_wr), .commit_rd_i(commit_rd),
    .snap_i(match), .wbuf_i(wbuf), .in_rd_i, .out_wr_i, .out_wdata_i,
    .in_data_o, .in_full_o, .out_full_o, .rd_byte_o(rd_byte)
  );

  assign busy_o = (st == ST_WDAT) || (st == ST_HTAR0) || (st == ST_HTAR1) ||
                  (st == ST_SYNC) || (st == ST_RDAT);
endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lframe_ni,
  input logic [3:0]        lad_o,
  input logic              lad_oe_o,
  input logic              out_wr_i,
  input logic              out_full_o,
  input logic [DATA_W-1:0] in_data_o,
  input logic              in_full_o,
  input logic              busy_o
);
  // R2: target drive always opens with the ready sync
  p_sync_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> lad_o == 4'b0000);

  // R7: frame low silences the target next clock
  p_abort_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_ni |=> !lad_oe_o);

  // R6: input flag only rises during the recovery nibble
  p_in_full_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_full_o) |-> lad_oe_o && lad_o == 4'b1111 && !busy_o);

  // R6: input data only changes during the recovery nibble
  p_in_data_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data_o != $past(in_data_o)) |-> lad_oe_o && lad_o == 4'b1111);

  // R6: output flag only clears during the recovery nibble
  p_out_clear_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_full_o) |-> lad_oe_o && lad_o == 4'b1111);

  // R9: local load always leaves the output flag set
  p_out_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_wr_i |=> out_full_o);
endmodule

bind lpc_io_target lpc_io_target_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_lpc_io_target.sv
module tb_lpc_io_target;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lframe_ni = 1'b1;
  logic [3:0]  lad_i = 4'hF;
  logic [3:0]  lad_o;
  logic        lad_oe_o;
  logic [15:0] host_addr_i = 16'h0CA2;
  logic        out_wr_i = 1'b0;
  logic [7:0]  out_wdata_i = '0;
  logic        out_full_o;
  logic        in_rd_i = 1'b0;
  logic [7:0]  in_data_o;
  logic        in_full_o;
  logic        busy_o;

  lpc_io_target dut (.*);

  always #2 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] m_in_data = '0, m_out_data = '0;
  logic       m_in_full = 0, m_out_full = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic lf, input logic [3:0] n, input logic rs,
                      input logic ws, input logic [7:0] wd);
    @(negedge clk_i);
    lframe_ni = lf; lad_i = n; in_rd_i = rs; out_wr_i = ws; out_wdata_i = wd;
    @(posedge clk_i);
    #1;
    in_rd_i = 0; out_wr_i = 0;
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " in_full"}, in_full_o, m_in_full);
    chk({tag, " in_data"}, in_data_o, m_in_data);
    chk({tag, " out_full"}, out_full_o, m_out_full);
  endtask

  task automatic loc_write(input logic [7:0] d);
    step(1, 4'hF, 0, 1, d);
    m_out_data = d; m_out_full = 1;
    chk_flags("R9 local load");
  endtask

  task automatic loc_release();
    step(1, 4'hF, 1, 0, 8'h00);
    m_in_full = 0;
    chk_flags("R9 local release");
  endtask

  // one 13-clock bus cycle; abort_at/rd_at/owr_at are step numbers (0 = none)
  task automatic bus_cycle(input string tag, input logic [3:0] typ, input logic [15:0] addr,
                           input logic [7:0] wd, input int abort_at, input int rd_at,
                           input int owr_at, input logic [7:0] owd);
    bit wr   = (typ == 4'b0010);
    bit hit  = (typ == 4'b0000 || typ == 4'b0010) && addr == host_addr_i;
    logic [7:0] snap = m_out_data;
    for (int k = 1; k <= 13; k++) begin
      logic lf = 1; logic [3:0] n = 4'hF;
      bit live, eoe, ebusy; logic [3:0] elad = 4'h0;
      bit rs = (k == rd_at), ws = (k == owr_at);
      if (k == 1) n = 4'b0000;
      else if (k == 2) n = typ;
      else if (k <= 6) n = addr[(6-k)*4 +: 4];
      else if (wr && k == 7) n = wd[3:0];
      else if (wr && k == 8) n = wd[7:4];
      if (k == 1) lf = 0;
      if (k == abort_at) begin lf = 0; n = 4'hF; end
      step(lf, n, rs, ws, owd);
      live = hit && !(abort_at != 0 && abort_at <= k);
      // model: release, then host commit, then local load
      if (rs) m_in_full = 0;
      if (live && k == 11) begin
        if (wr) begin m_in_data = wd; m_in_full = 1; end
        else m_out_full = 0;
      end
      if (ws) begin m_out_data = owd; m_out_full = 1; end
      eoe = 0;
      if (live) begin
        if (!wr) begin
          if (k == 8)  begin eoe = 1; elad = 4'h0; end
          if (k == 9)  begin eoe = 1; elad = snap[3:0]; end
          if (k == 10) begin eoe = 1; elad = snap[7:4]; end
          if (k == 11) begin eoe = 1; elad = 4'hF; end
        end else begin
          if (k == 10) begin eoe = 1; elad = 4'h0; end
          if (k == 11) begin eoe = 1; elad = 4'hF; end
        end
      end
      ebusy = live && k >= 6 && k <= 10;
      chk({tag, " oe"}, lad_oe_o, eoe);
      if (eoe) chk({tag, " lad"}, lad_o, elad);
      chk({tag, " R8 busy"}, busy_o, ebusy);
      chk_flags(tag);
    end
    step(1, 4'hF, 0, 0, 8'h00);
    chk({tag, " idle oe"}, lad_oe_o, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 reset oe", lad_oe_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset in_full", in_full_o, 0);
    chk("R1 reset out_full", out_full_o, 0);
    #10 rst_ni = 1;
    step(1, 4'hF, 0, 0, 8'h00);
    chk_flags("R1 after reset");

    loc_write(8'hA5);
    bus_cycle("R2 read", 4'b0000, 16'h0CA2, 8'h00, 0, 0, 0, 8'h00);
    bus_cycle("R3 write", 4'b0010, 16'h0CA2, 8'h3C, 0, 0, 0, 8'h00);
    loc_release();
    bus_cycle("R4 write other addr", 4'b0010, 16'h0CA3, 8'h99, 0, 0, 0, 8'h00);
    bus_cycle("R4 read other addr", 4'b0000, 16'h8CA2, 8'h00, 0, 0, 0, 8'h00);
    bus_cycle("R5 other type", 4'b0100, 16'h0CA2, 8'h11, 0, 0, 0, 8'h00);
    bus_cycle("R7 write abort turnaround", 4'b0010, 16'h0CA2, 8'h66, 9, 0, 0, 8'h00);
    bus_cycle("R7 write abort sync", 4'b0010, 16'h0CA2, 8'h67, 11, 0, 0, 8'h00);
    loc_write(8'h5A);
    bus_cycle("R7 read abort data", 4'b0000, 16'h0CA2, 8'h00, 9, 0, 0, 8'h00);
    bus_cycle("R7 read abort last data", 4'b0000, 16'h0CA2, 8'h00, 11, 0, 0, 8'h00);
    bus_cycle("R9 read vs local load", 4'b0000, 16'h0CA2, 8'h00, 0, 0, 11, 8'h77);
    bus_cycle("R9 write vs release", 4'b0010, 16'h0CA2, 8'hC3, 0, 11, 0, 8'h00);
    bus_cycle("R6 abort after commit", 4'b0010, 16'h0CA2, 8'h81, 12, 0, 0, 8'h00);
    host_addr_i = 16'hFFFF;
    bus_cycle("R4 new host addr read", 4'b0000, 16'hFFFF, 8'h00, 0, 0, 0, 8'h00);
    bus_cycle("R4 old addr ignored", 4'b0010, 16'h0CA2, 8'h12, 0, 0, 0, 8'h00);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule